// File: doc/BRIEF.md
# Memory-Resident Register File Bus Unit

This block lets a processor keep its sixteen general registers in ordinary external RAM instead of in on-chip flip-flops. Only three values live inside: a workspace pointer, a program counter and a status word. An execution core hands the block a request, such as "read register 5", "write register 3" or "write this byte at that address". The block turns the request into one or more 16-bit bus cycles at the right memory address and answers with a one-cycle done pulse.

Register n sits at the workspace pointer plus 2·n, with the sum wrapping modulo 2^16. Loading a new workspace pointer therefore swaps the whole register set in a single step, which is a cheap context switch. The same words can also be reached by plain memory requests. The external bus is one word wide and has no byte enables. For that reason every word write starts with a wasted read of the target word, and a byte write is done as read, merge, write of the containing word.

A single state machine drives the sequence through these states:
- ST_IDLE: waits for a request.
- ST_FETCH: the read cycle of a read request.
- ST_DUMMY: the throw-away read before a word write.
- ST_MERGE: the read half of a byte write.
- ST_STORE: the write cycle.
- ST_DONE: the response cycle.

Its transitions are:
- ST_IDLE goes to ST_FETCH on a read, to ST_DUMMY on a word write, to ST_MERGE on a byte write, and straight to ST_DONE on a pointer, counter or status load.
- ST_FETCH goes to ST_DONE on ready.
- ST_DUMMY and ST_MERGE go to ST_STORE on ready.
- ST_STORE goes to ST_DONE on ready.
- ST_DONE always returns to ST_IDLE.

Top module: `wsr_bus_unit`

## Requirements
- R1: After reset the workspace pointer, program counter and status word are 0, and `busy`, `resp_done`, `bus_rd` and `bus_wr` are all low.
- R2: Op code 5 loads `req_wdata` into the workspace pointer with bit 0 forced to 0. It runs no bus cycle and gives `resp_done` one cycle after acceptance.
- R3: Op code 0 (register read) runs exactly one read cycle at the workspace pointer + 2·`req_reg` and returns that word on `resp_rdata` while `resp_done` is high.
- R4: Op code 1 (register write) runs a read cycle and then a write cycle of `req_wdata`, both at the same register address, and no other bus cycle.
- R5: After the workspace pointer changes, the same register number reaches the word at the new base.
- R6: The register address wraps modulo 2^16.
- R7: Op codes 2 (word read) and 3 (word write) reach memory at `req_addr` with bit 0 cleared. A word write is preceded by a read cycle at the same address, and both byte addresses of a word give the same access.
- R8: Op code 4 (byte write) reads the word at `req_addr` with bit 0 cleared, then writes it back with one byte replaced by `req_wdata[7:0]`. `req_addr[0]`=0 replaces bits 15:8 and 1 replaces bits 7:0; the other byte is kept.
- R9: A bus cycle holds its strobe, address and write data until `bus_ready` is sampled high. `bus_rd` and `bus_wr` are never high together, and `bus_addr[0]` is 0 during every cycle.
- R10: While `busy` is high, `req_valid` is ignored: no register changes and no bus cycle is started by it.
- R11: `resp_done` is high for exactly one cycle. `busy` is high from acceptance through that cycle and low after it.
- R12: Op codes 6 and 7 load `req_wdata` into the program counter and the status word respectively, with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_op | input | 3 | Operation code (see requirements) |
| req_reg | input | 4 | Register number for ops 0 and 1 |
| req_addr | input | 16 | Byte address for ops 2, 3 and 4 |
| req_wdata | input | 16 | Write or load data |
| busy | output | 1 | A sequence is in progress |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read result, valid with resp_done on reads |
| ws_ptr | output | 16 | Workspace pointer |
| prog_ctr | output | 16 | Program counter |
| status_word | output | 16 | Status word |
| bus_addr | output | 16 | External word address (bit 0 always 0) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled with bus_ready |
| bus_ready | input | 1 | Ends the current bus cycle |

## Verification
The bench checks the exact bus log of each request:
- A word write that skipped the dummy read would log a single cycle instead of two.
- A byte write that merged into the wrong lane would corrupt the byte that should have been kept.

It moves the workspace pointer, including to a base just below 0xFFFF. A design that cached register contents, or that carried out of 16 bits, would then hit the wrong word. Wait states stretch each bus cycle, and the measured latency from acceptance to done exposes a sequence that fails to hold for ready or that double-counts a cycle. A pointer load offered while a write is in flight must leave the pointer untouched; a design that accepted requests while busy would overwrite it.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [2:0] {
        OP_RD_REG  = 3'd0,
        OP_WR_REG  = 3'd1,
        OP_RD_WORD = 3'd2,
        OP_WR_WORD = 3'd3,
        OP_WR_BYTE = 3'd4,
        OP_SET_WP  = 3'd5,
        OP_SET_PC  = 3'd6,
        OP_SET_ST  = 3'd7
    } wsr_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DUMMY,
        ST_MERGE,
        ST_STORE,
        ST_DONE
    } wsr_state_e;
endpackage

// File: rtl/wsr_ctx_regs.sv
module wsr_ctx_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_wp,
    input  logic          ld_pc,
    input  logic          ld_st,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] wp,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] st
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            pc <= '0;
            st <= '0;
        end else begin
            if (ld_wp) wp <= {din[DW-1:1], 1'b0};
            if (ld_pc) pc <= din;
            if (ld_st) st <= din;
        end
    end

    // R2: the base pointer is always word aligned
    a_r2_wp_aligned: assert property (@(posedge clk) disable iff (!rst_n) wp[0] == 1'b0);

    // R10: the pointer only moves on a load
    a_r10_wp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_wp |=> $stable(wp));
endmodule

// File: rtl/wsr_addr_merge.sv
module wsr_addr_merge #(
    parameter int DW     = 16,
    parameter int RIDX_W = 4
) (
    input  logic              is_reg,
    input  logic [RIDX_W-1:0] regnum,
    input  logic [DW-1:0]     addr,
    input  logic [DW-1:0]     wp,
    input  logic              lane,
    input  logic [DW/2-1:0]   byte_in,
    input  logic [DW-1:0]     rdata,
    output logic [DW-1:0]     tgt_addr,
    output logic [DW-1:0]     merged
);
    localparam int BW = DW / 2;

    logic [DW-1:0] reg_off;
    assign reg_off = {{(DW-RIDX_W-1){1'b0}}, regnum, 1'b0};

    always_comb begin
        if (is_reg) tgt_addr = wp + reg_off;
        else        tgt_addr = {addr[DW-1:1], 1'b0};
    end

    always_comb begin
        if (lane) merged = {rdata[DW-1:BW], byte_in};
        else      merged = {byte_in, rdata[BW-1:0]};
    end
endmodule

// File: rtl/wsr_bus_fsm.sv
module wsr_bus_fsm
    import wsr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  wsr_op_e       req_op,
    input  logic          req_lane,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] tgt_addr,
    input  logic [DW-1:0] merged,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          busy,
    output logic          resp_done,
    output logic [DW-1:0] resp_rdata,
    output logic          ld_wp,
    output logic          ld_pc,
    output logic          ld_st,
    output logic          lane_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr
);
    wsr_state_e    state_q, state_d;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] rdata_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (req_op)
                        OP_RD_REG, OP_RD_WORD:            state_d = ST_FETCH;
                        OP_WR_REG, OP_WR_WORD:            state_d = ST_DUMMY;
                        OP_WR_BYTE:                       state_d = ST_MERGE;
                        OP_SET_WP, OP_SET_PC, OP_SET_ST:  state_d = ST_DONE;
                        default:                          state_d = ST_DONE;
                    endcase
                end
            end
            ST_FETCH: if (bus_ready) state_d = ST_DONE;
            ST_DUMMY: if (bus_ready) state_d = ST_STORE;
            ST_MERGE: if (bus_ready) state_d = ST_STORE;
            ST_STORE: if (bus_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            lane_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= tgt_addr;
                wdata_q <= req_wdata;
                lane_q  <= req_lane;
            end
            if (state_q == ST_FETCH && bus_ready) rdata_q <= bus_rdata;
            if (state_q == ST_MERGE && bus_ready) wdata_q <= merged;
        end
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        resp_done  = (state_q == ST_DONE);
        bus_rd     = (state_q == ST_FETCH) || (state_q == ST_DUMMY) || (state_q == ST_MERGE);
        bus_wr     = (state_q == ST_STORE);
        bus_addr   = addr_q;
        resp_rdata = rdata_q;
        ld_wp      = accept && (req_op == OP_SET_WP);
        ld_pc      = accept && (req_op == OP_SET_PC);
        ld_st      = accept && (req_op == OP_SET_ST);
    end

    // R9: strobes are exclusive
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));

    // R9: address and data hold while ready is low
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && !bus_ready |=> $stable(bus_addr) && $stable(wdata_q));

    // R4: a write cycle always follows a read cycle
    a_r4_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rd));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done && !busy);

    // R10: a bus cycle only runs while busy
    a_r10_busy_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> busy);
endmodule

// File: rtl/wsr_bus_unit.sv
module wsr_bus_unit
    import wsr_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NREGS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [$clog2(NREGS)-1:0] req_reg,
    input  logic [DW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    output logic                     busy,
    output logic                     resp_done,
    output logic [DW-1:0]            resp_rdata,
    output logic [DW-1:0]            ws_ptr,
    output logic [DW-1:0]            prog_ctr,
    output logic [DW-1:0]            status_word,
    output logic [DW-1:0]            bus_addr,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic [DW-1:0]            bus_wdata,
    input  logic [DW-1:0]            bus_rdata,
    input  logic                     bus_ready
);
    localparam int RIDX_W = $clog2(NREGS);

    wsr_op_e       op;
    logic          is_reg;
    logic          ld_wp, ld_pc, ld_st;
    logic          lane_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] tgt_addr;
    logic [DW-1:0] merged;

    assign op     = wsr_op_e'(req_op);
    assign is_reg = (op == OP_RD_REG) || (op == OP_WR_REG);

    wsr_ctx_regs #(.DW(DW)) u_ctx (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_wp (ld_wp),
        .ld_pc (ld_pc),
        .ld_st (ld_st),
        .din   (req_wdata),
        .wp    (ws_ptr),
        .pc    (prog_ctr),
        .st    (status_word)
    );

    wsr_addr_merge #(.DW(DW), .RIDX_W(RIDX_W)) u_addr (
        .is_reg   (is_reg),
        .regnum   (req_reg),
        .addr     (req_addr),
        .wp       (ws_ptr),
        .lane     (lane_q),
        .byte_in  (wdata_q[DW/2-1:0]),
        .rdata    (bus_rdata),
        .tgt_addr (tgt_addr),
        .merged   (merged)
    );

    wsr_bus_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (op),
        .req_lane   (req_addr[0]),
        .req_wdata  (req_wdata),
        .tgt_addr   (tgt_addr),
        .merged     (merged),
        .bus_rdata  (bus_rdata),
        .bus_ready  (bus_ready),
        .busy       (busy),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata),
        .ld_wp      (ld_wp),
        .ld_pc      (ld_pc),
        .ld_st      (ld_st),
        .lane_q     (lane_q),
        .wdata_q    (wdata_q),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr)
    );

    assign bus_wdata = wdata_q;

    // R9: only whole words reach the bus
    a_r9_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_addr[0] == 1'b0));
endmodule

// File: tb/test_wsr_bus_unit.sv
module test_wsr_bus_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [3:0]  req_reg = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, resp_done;
    logic [15:0] resp_rdata, ws_ptr, prog_ctr, status_word, bus_addr, bus_wdata;
    logic        bus_rd, bus_wr;
    logic [15:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int waitn    = 0;
    int bcnt     = 0;
    int log_n    = 0;
    logic        log_wr   [0:15];
    logic [15:0] log_addr [0:15];
    logic [15:0] mem [0:255];
    logic [15:0] rd_res;
    int          lat;

    always #10 clk = ~clk;

    wsr_bus_unit i_wsr_bus_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_reg(req_reg), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .resp_done(resp_done), .resp_rdata(resp_rdata),
        .ws_ptr(ws_ptr), .prog_ctr(prog_ctr), .status_word(status_word),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // memory model with programmable wait states
    always @(negedge clk) begin
        if (bus_ready) begin
            bus_ready = 1'b0;
            bcnt = 0;
        end else if (bus_rd || bus_wr) begin
            if (bcnt >= waitn) begin
                bus_ready = 1'b1;
                if (log_n < 16) begin
                    log_wr[log_n]   = bus_wr;
                    log_addr[log_n] = bus_addr;
                end
                log_n++;
                if (bus_wr) mem[bus_addr[8:1]] = bus_wdata;
                bus_rdata = mem[bus_addr[8:1]];
            end else begin
                bcnt++;
            end
        end
    end

    initial begin
        #4000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] rn,
                         input logic [15:0] a, input logic [15:0] d);
        log_n = 0;
        req_op = op; req_reg = rn; req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        lat = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (resp_done) break;
            if (k == 0) check("R11 busy after accept", busy, 1'b1);
        end
        rd_res = resp_rdata;
        check("R11 busy during done", busy, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R11 done single cycle", resp_done, 1'b0);
        check("R11 busy cleared", busy, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 wp", ws_ptr, 16'h0);
        check("R1 pc", prog_ctr, 16'h0);
        check("R1 st", status_word, 16'h0);
        check("R1 busy/done/strobes", {busy, resp_done, bus_rd, bus_wr}, 4'b0);
    endtask

    task automatic t_loads;
        issue(3'd5, 4'd0, 16'h0, 16'h0121);
        check("R2 wp bit0 cleared", ws_ptr, 16'h0120);
        check("R2 no bus cycle", log_n, 0);
        check("R2 latency", lat, 1);
        issue(3'd6, 4'd0, 16'h0, 16'hC0DE);
        check("R12 pc load", prog_ctr, 16'hC0DE);
        check("R12 no bus cycle", log_n, 0);
        issue(3'd7, 4'd0, 16'h0, 16'h8421);
        check("R12 st load", status_word, 16'h8421);
        check("R12 wp untouched", ws_ptr, 16'h0120);
    endtask

    task automatic t_reg_read;
        mem[(16'h012A >> 1) & 255] = 16'hBEEF;
        issue(3'd0, 4'd5, 16'h0, 16'h0);
        check("R3 read data", rd_res, 16'hBEEF);
        check("R3 one cycle", log_n, 1);
        check("R3 kind", log_wr[0], 1'b0);
        check("R3 address", log_addr[0], 16'h012A);
    endtask

    task automatic t_reg_write;
        issue(3'd1, 4'd3, 16'h0, 16'h1234);
        check("R4 two cycles", log_n, 2);
        check("R4 dummy read first", {log_wr[0], log_addr[0]}, {1'b0, 16'h0126});
        check("R4 write second", {log_wr[1], log_addr[1]}, {1'b1, 16'h0126});
        check("R4 memory", mem[(16'h0126 >> 1) & 255], 16'h1234);
    endtask

    task automatic t_context;
        mem[(16'h018A >> 1) & 255] = 16'h5A5A;
        issue(3'd5, 4'd0, 16'h0, 16'h0180);
        issue(3'd0, 4'd5, 16'h0, 16'h0);
        check("R5 new base address", log_addr[0], 16'h018A);
        check("R5 new base data", rd_res, 16'h5A5A);
        issue(3'd2, 4'd0, 16'h018B, 16'h0);
        check("R7 odd byte addr -> word", log_addr[0], 16'h018A);
        check("R7 word read data", rd_res, 16'h5A5A);
        issue(3'd3, 4'd0, 16'h0191, 16'h3C3C);
        check("R7 word write cycles", log_n, 2);
        check("R7 dummy read addr", {log_wr[0], log_addr[0]}, {1'b0, 16'h0190});
        check("R7 write addr", {log_wr[1], log_addr[1]}, {1'b1, 16'h0190});
        issue(3'd0, 4'd8, 16'h0, 16'h0);
        check("R7 register sees memory write", rd_res, 16'h3C3C);
    endtask

    task automatic t_wrap;
        issue(3'd5, 4'd0, 16'h0, 16'hFFF8);
        issue(3'd1, 4'd7, 16'h0, 16'h9876);
        check("R6 wrapped address", log_addr[1], 16'h0006);
        check("R6 memory", mem[3], 16'h9876);
    endtask

    task automatic t_byte;
        mem[(16'h0200 >> 1) & 255] = 16'hA5C3;
        issue(3'd4, 4'd0, 16'h0200, 16'h007E);
        check("R8 rmw cycles", log_n, 2);
        check("R8 read then write", {log_wr[0], log_wr[1]}, 2'b01);
        check("R8 addr", log_addr[1], 16'h0200);
        check("R8 high byte lane", mem[(16'h0200 >> 1) & 255], 16'h7EC3);
        issue(3'd4, 4'd0, 16'h0201, 16'hFF11);
        check("R8 low byte lane addr", log_addr[1], 16'h0200);
        check("R8 low byte lane", mem[(16'h0200 >> 1) & 255], 16'h7E11);
    endtask

    task automatic t_wait;
        issue(3'd5, 4'd0, 16'h0, 16'h0120);
        waitn = 4;
        issue(3'd0, 4'd5, 16'h0, 16'h0);
        check("R9 read latency with waits", lat, 6);
        check("R9 single cycle with waits", log_n, 1);
        check("R9 data with waits", rd_res, 16'hBEEF);
        issue(3'd1, 4'd2, 16'h0, 16'h4455);
        check("R9 write latency with waits", lat, 12);
        check("R9 write data with waits", mem[(16'h0124 >> 1) & 255], 16'h4455);
        waitn = 0;
    endtask

    task automatic t_busy;
        waitn = 3;
        log_n = 0;
        req_op = 3'd1; req_reg = 4'd1; req_wdata = 16'h6677; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        req_op = 3'd5; req_wdata = 16'h0300; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (resp_done) break;
            @(posedge clk); @(negedge clk);
        end
        @(posedge clk); @(negedge clk);
        check("R10 wp unchanged", ws_ptr, 16'h0120);
        check("R10 no extra bus cycle", log_n, 2);
        check("R10 original write done", mem[(16'h0122 >> 1) & 255], 16'h6677);
        waitn = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_loads;
        t_reg_read;
        t_reg_write;
        t_context;
        t_wrap;
        t_byte;
        t_wait;
        t_busy;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule